// File: doc/BRIEF.md
# Synchronous Host Bus Slave with Wait Stall

This block sits between an external microprocessor bus and an on-chip access port. Every action happens on rising edges of the bus clock. The host addresses a 21-bit space. A space-select bit chooses between memory and registers. The host marks the byte lanes it wants with separate active-low read and write strobes, one pair per lane of the 16-bit data bus.

Once the block sees chip select and a strobe low together, it drives an active-low wait line low and turns the host cycle into a single internal request. It keeps the host stalled until the internal side acknowledges, whatever the latency. It then drives wait high. When the host lets go of every strobe, the block floats wait again. Read data is driven only on the lanes being read, and only while the read lasts.

Tri-state pins appear as value/enable pairs. If the host releases its strobes before the acknowledge, the internal request is withdrawn.

Top module: `mpu_wait_slave`

## Requirements
- R1: While reset is high at a rising edge, the next state has wait undriven (`bus_wait_oe`=0), both data lane enables at 0 and `req_valid`=0. Reset is synchronous and active high.
- R2: From idle, the block responds when `bus_cs_n`=0 and any bit of `bus_rd_n` or `bus_wr_n` is 0 at a rising edge. After that edge it drives `bus_wait_oe`=1 with `bus_wait_n`=0. If chip select is high, the strobes are ignored.
- R3: On the second rising edge of a cycle, `req_valid` rises. The request carries the address, space select, direction and byte enables sampled on the first edge. For writes, `req_wdata` is the value of `bus_din` on the second edge.
- R4: `req_valid` and its fields stay constant, and wait stays driven low, until `req_ack` is seen high at a rising edge. This holds for any acknowledge latency.
- R5: On the edge where `req_ack` is high with `req_valid`=1, `req_valid` falls and `bus_wait_n` goes high while still driven. For a read, `bus_dout` holds `req_rdata` on the enabled lanes from that same edge.
- R6: A write strobe low makes the cycle a write with `req_be` = ~`bus_wr_n` (bit 0 is the lane on bits 7:0), even if read strobes are also low. Otherwise the cycle is a read with `req_be` = ~`bus_rd_n`.
- R7: During a read, `bus_dout_oe[i]` is 1 only for lanes in `req_be`, from the first edge until release. During a write, `bus_dout_oe` stays 0.
- R8: After the acknowledge, the first edge with all four strobes high returns the block to idle. That edge clears `bus_wait_oe` and `bus_dout_oe`.
- R9: If all strobes are high at an edge before the acknowledge, the request is withdrawn. `req_valid`=0 and all enables go to 0 on that edge, and an `req_ack` on the same edge has no effect.
- R10: A reset in the middle of a cycle drops any pending request and floats all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 21 | Host address |
| bus_mem | input | 1 | Space select, 1 = memory, 0 = register |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 2 | Per-lane read strobes, active low |
| bus_wr_n | input | 2 | Per-lane write strobes, active low |
| bus_din | input | 16 | Data from host |
| bus_dout | output | 16 | Read data to host |
| bus_dout_oe | output | 2 | Per-lane drive enable for bus_dout |
| bus_wait_n | output | 1 | Wait level, 0 = stall |
| bus_wait_oe | output | 1 | Drive enable for wait |
| req_valid | output | 1 | Internal request pending |
| req_addr | output | 21 | Request address |
| req_mem | output | 1 | Request space select |
| req_write | output | 1 | Request direction, 1 = write |
| req_be | output | 2 | Request byte enables |
| req_wdata | output | 16 | Request write data |
| req_ack | input | 1 | Internal completion |
| req_rdata | input | 16 | Internal read data, valid with req_ack |

## Verification
The hardest situations to reach are a host that gives up mid-cycle and a reset that lands in mid-cycle. In particular, the case where the strobe release and the acknowledge arrive on the same edge must follow the withdrawal rule.

The stimulus reaches these by timing the strobe release at a chosen falling edge, either in the setup cycle or in the request cycle. In the second case it also raises `req_ack` in that same half-cycle. The normal path is swept over every combination of lane pattern, direction, space and acknowledge latency from 1 to 4. Each write's data only becomes valid after the first edge, so that sampling on the second edge is distinguished from sampling on the first.

// File: rtl/mws_pkg.sv
package mws_pkg;
    localparam int MWS_ADDR_W = 21;
    localparam int MWS_DATA_W = 16;
    localparam int MWS_LANE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_REQ   = 2'd2,
        ST_DONE  = 2'd3
    } mws_state_e;

    typedef struct packed {
        logic write;
        logic mem;
    } mws_kind_t;

    typedef struct packed {
        logic load_hdr;
        logic load_wdata;
        logic capture;
        logic clear;
    } mws_ctl_t;
endpackage

// File: rtl/mws_ctrl.sv
module mws_ctrl
    import mws_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     released,
    input  logic     ack,
    output mws_ctl_t ctl,
    output logic     wait_n,
    output logic     wait_oe,
    output logic     req_valid
);
    mws_state_e state;

    always_comb begin
        ctl.load_hdr   = (state == ST_IDLE) && start;
        ctl.load_wdata = (state == ST_SETUP) && !released;
        ctl.capture    = (state == ST_REQ) && !released && ack;
        ctl.clear      = (state != ST_IDLE) && released;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            wait_n    <= 1'b1;
            wait_oe   <= 1'b0;
            req_valid <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state   <= ST_SETUP;
                    wait_oe <= 1'b1;
                    wait_n  <= 1'b0;
                end
                ST_SETUP: if (released) begin
                    state   <= ST_IDLE;
                    wait_oe <= 1'b0;
                    wait_n  <= 1'b1;
                end else begin
                    state     <= ST_REQ;
                    req_valid <= 1'b1;
                end
                ST_REQ: if (released) begin
                    state     <= ST_IDLE;
                    req_valid <= 1'b0;
                    wait_oe   <= 1'b0;
                    wait_n    <= 1'b1;
                end else if (ack) begin
                    state     <= ST_DONE;
                    req_valid <= 1'b0;
                    wait_n    <= 1'b1;
                end
                ST_DONE: if (released) begin
                    state   <= ST_IDLE;
                    wait_oe <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mws_lane.sv
module mws_lane #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_oe,
    input  logic          lane_en,
    input  logic          clr,
    input  logic          cap,
    input  logic [LW-1:0] rdata,
    output logic [LW-1:0] dout,
    output logic          oe
);
    always_ff @(posedge clk) begin
        if (rst || clr)   oe <= 1'b0;
        else if (set_oe)  oe <= lane_en;
    end

    always_ff @(posedge clk) begin
        if (rst)          dout <= '0;
        else if (set_oe)  dout <= '0;
        else if (cap)     dout <= rdata;
    end
endmodule

// File: rtl/mpu_wait_slave.sv
module mpu_wait_slave
    import mws_pkg::*;
#(
    parameter int ADDR_W = MWS_ADDR_W,
    parameter int DATA_W = MWS_DATA_W,
    parameter int LANE_W = MWS_LANE_W,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_mem,
    input  logic              bus_cs_n,
    input  logic [LANES-1:0]  bus_rd_n,
    input  logic [LANES-1:0]  bus_wr_n,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic [LANES-1:0]  bus_dout_oe,
    output logic              bus_wait_n,
    output logic              bus_wait_oe,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_mem,
    output logic              req_write,
    output logic [LANES-1:0]  req_be,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              req_ack,
    input  logic [DATA_W-1:0] req_rdata
);
    mws_ctl_t  ctl;
    mws_kind_t kind;
    logic      is_write;
    logic      released;
    logic      start;
    logic [LANES-1:0] lane_sel;

    always_comb begin
        is_write = !(&bus_wr_n);
        released = (&bus_rd_n) && (&bus_wr_n);
        start    = !bus_cs_n && !released;
        lane_sel = is_write ? ~bus_wr_n : ~bus_rd_n;
    end

    mws_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .released  (released),
        .ack       (req_ack),
        .ctl       (ctl),
        .wait_n    (bus_wait_n),
        .wait_oe   (bus_wait_oe),
        .req_valid (req_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_addr  <= '0;
            kind      <= '0;
            req_be    <= '0;
            req_wdata <= '0;
        end else begin
            if (ctl.load_hdr) begin
                req_addr   <= bus_addr;
                kind.write <= is_write;
                kind.mem   <= bus_mem;
                req_be     <= lane_sel;
            end
            if (ctl.load_wdata && kind.write)
                req_wdata <= bus_din;
        end
    end

    assign req_write = kind.write;
    assign req_mem   = kind.mem;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        mws_lane #(.LW(LANE_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .set_oe  (ctl.load_hdr),
            .lane_en (!is_write && lane_sel[g]),
            .clr     (ctl.clear),
            .cap     (ctl.capture),
            .rdata   (req_rdata[g*LANE_W +: LANE_W]),
            .dout    (bus_dout[g*LANE_W +: LANE_W]),
            .oe      (bus_dout_oe[g])
        );
    end
endmodule

// File: rtl/mws_checker.sv
module mws_checker #(
    parameter int ADDR_W = 21,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_cs_n,
    input logic [LANES-1:0]  bus_rd_n,
    input logic [LANES-1:0]  bus_wr_n,
    input logic [LANES-1:0]  bus_dout_oe,
    input logic              bus_wait_n,
    input logic              bus_wait_oe,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ack
);
    logic rst_q = 1'b0;
    logic all_up;

    assign all_up = (&bus_rd_n) && (&bus_wr_n);

    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q) begin
            AST_RESET_IDLE: assert (!bus_wait_oe && bus_dout_oe == '0 && !req_valid); // R1
        end
    end

    AST_DETECT_STALL: assert property (@(posedge clk) disable iff (rst)
        (!bus_wait_oe && !bus_cs_n && !all_up) |=> (bus_wait_oe && !bus_wait_n)); // R2

    AST_REQ_STALLS: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (bus_wait_oe && !bus_wait_n)); // R4

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ack && !all_up) |=> (req_valid && $stable(req_addr))); // R4

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ack && !all_up) |=> (!req_valid && bus_wait_oe && bus_wait_n)); // R5

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |-> (bus_dout_oe == '0)); // R7

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && all_up) |=> (!req_valid && !bus_wait_oe && bus_dout_oe == '0)); // R9
endmodule

bind mpu_wait_slave mws_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_cs_n    (bus_cs_n),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .bus_dout_oe (bus_dout_oe),
    .bus_wait_n  (bus_wait_n),
    .bus_wait_oe (bus_wait_oe),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_ack     (req_ack)
);

// File: tb/mpu_wait_slave_test.sv
`timescale 1ns/1ps
module mpu_wait_slave_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [20:0] bus_addr;
    logic        bus_mem;
    logic        bus_cs_n;
    logic [1:0]  bus_rd_n;
    logic [1:0]  bus_wr_n;
    logic [15:0] bus_din;
    logic [15:0] bus_dout;
    logic [1:0]  bus_dout_oe;
    logic        bus_wait_n;
    logic        bus_wait_oe;
    logic        req_valid;
    logic [20:0] req_addr;
    logic        req_mem;
    logic        req_write;
    logic [1:0]  req_be;
    logic [15:0] req_wdata;
    logic        req_ack;
    logic [15:0] req_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mpu_wait_slave uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_mem(bus_mem),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe),
        .bus_wait_n(bus_wait_n), .bus_wait_oe(bus_wait_oe),
        .req_valid(req_valid), .req_addr(req_addr), .req_mem(req_mem),
        .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
        .req_ack(req_ack), .req_rdata(req_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_idle();
        bus_cs_n = 1'b1;
        bus_rd_n = 2'b11;
        bus_wr_n = 2'b11;
        bus_din  = 16'h0;
    endtask

    // One full host cycle; ack arrives lat cycles after the request appears.
    task automatic txn(input bit wr, input bit mem, input logic [1:0] be,
                       input int lat, input logic [20:0] a, input logic [15:0] d);
        logic [15:0] lane_mask;
        lane_mask = {{8{be[1]}}, {8{be[0]}}};
        bus_addr = a;
        bus_mem  = mem;
        bus_cs_n = 1'b0;
        bus_din  = ~d;
        if (wr) bus_wr_n = ~be; else bus_rd_n = ~be;
        tick();
        chk("R2 wait driven", {30'd0, bus_wait_oe, bus_wait_n}, 32'h2);
        chk("R7 lane enables", bus_dout_oe, wr ? 32'h0 : be);
        chk("R3 no request yet", req_valid, 0);
        bus_din  = d;
        bus_addr = ~a;
        tick();
        chk("R3 request raised", req_valid, 1);
        chk("R3 address", req_addr, a);
        chk("R3 space", req_mem, mem);
        chk("R6 direction", req_write, wr);
        chk("R6 byte enables", req_be, be);
        if (wr) chk("R3 write data on second edge", req_wdata, d);
        bus_din = 16'h0;
        for (int k = 1; k < lat; k++) begin
            tick();
            chk("R4 request held", {30'd0, req_valid, bus_wait_n}, 32'h2);
            chk("R4 fields stable", req_addr, a);
        end
        req_ack   = 1'b1;
        req_rdata = d;
        tick();
        req_ack   = 1'b0;
        req_rdata = 16'h0;
        chk("R5 wait high driven", {30'd0, bus_wait_oe, bus_wait_n}, 32'h3);
        chk("R5 request dropped", req_valid, 0);
        if (!wr) chk("R5 read data", bus_dout & lane_mask, d & lane_mask);
        chk("R7 lanes during done", bus_dout_oe, wr ? 32'h0 : be);
        bus_idle();
        tick();
        chk("R8 wait floated", bus_wait_oe, 0);
        chk("R8 data floated", bus_dout_oe, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int idx;
        rst = 1'b1;
        bus_addr = '0;
        bus_mem = 1'b0;
        req_ack = 1'b0;
        req_rdata = '0;
        bus_idle();
        @(negedge clk);
        tick();
        chk("R1 reset wait", bus_wait_oe, 0);
        chk("R1 reset lanes", bus_dout_oe, 0);
        chk("R1 reset request", req_valid, 0);
        rst = 1'b0;
        tick();

        // R2: strobes without chip select are ignored
        bus_rd_n = 2'b00;
        bus_wr_n = 2'b10;
        repeat (3) tick();
        chk("R2 no cs no wait", bus_wait_oe, 0);
        chk("R2 no cs no request", req_valid, 0);
        chk("R2 no cs no drive", bus_dout_oe, 0);
        bus_idle();
        tick();

        // Sweep: latency x direction x space x lane pattern
        idx = 0;
        for (int lat = 1; lat <= 4; lat++)
            for (int wr = 0; wr < 2; wr++)
                for (int mem = 0; mem < 2; mem++)
                    for (int be = 1; be < 4; be++) begin
                        txn(wr[0], mem[0], be[1:0], lat,
                            21'(lat * 21'h1_2345 + idx * 21'h0_0407),
                            16'(16'hA5C3 ^ (idx * 16'h0111)));
                        idx++;
                    end

        // R6: write strobe wins over read strobes
        bus_addr = 21'h1F_0F0F;
        bus_mem  = 1'b1;
        bus_cs_n = 1'b0;
        bus_rd_n = 2'b00;
        bus_wr_n = 2'b10;
        bus_din  = 16'h3C5A;
        tick();
        chk("R6 mixed no drive", bus_dout_oe, 0);
        tick();
        chk("R6 mixed is write", req_write, 1);
        chk("R6 mixed enables", req_be, 2'b01);
        req_ack = 1'b1;
        tick();
        req_ack = 1'b0;
        bus_idle();
        tick();

        // R9: release during setup cycle
        bus_addr = 21'h00_1234;
        bus_cs_n = 1'b0;
        bus_rd_n = 2'b01;
        tick();
        bus_idle();
        tick();
        chk("R9 setup abort request", req_valid, 0);
        chk("R9 setup abort wait", bus_wait_oe, 0);
        chk("R9 setup abort lanes", bus_dout_oe, 0);
        tick();
        chk("R9 stays idle", {30'd0, req_valid, bus_wait_oe}, 0);

        // R9: release on the same edge as ack
        bus_cs_n = 1'b0;
        bus_rd_n = 2'b00;
        tick();
        tick();
        chk("R9 request before abort", req_valid, 1);
        bus_idle();
        req_ack = 1'b1;
        req_rdata = 16'hDEAD;
        tick();
        req_ack = 1'b0;
        chk("R9 abort request", req_valid, 0);
        chk("R9 abort wait", bus_wait_oe, 0);
        chk("R9 abort lanes", bus_dout_oe, 0);
        tick();
        chk("R9 no late completion", {30'd0, bus_wait_oe, req_valid}, 0);
        txn(1'b0, 1'b0, 2'b11, 1, 21'h0A_BCDE, 16'h7E81);

        // R10: reset in the middle of a request
        bus_cs_n = 1'b0;
        bus_rd_n = 2'b10;
        tick();
        tick();
        chk("R10 request pending", req_valid, 1);
        rst = 1'b1;
        tick();
        chk("R10 reset drops request", req_valid, 0);
        chk("R10 reset floats wait", bus_wait_oe, 0);
        chk("R10 reset floats data", bus_dout_oe, 0);
        bus_idle();
        rst = 1'b0;
        tick();
        chk("R10 idle after reset", {30'd0, bus_wait_oe, req_valid}, 0);
        txn(1'b1, 1'b1, 2'b10, 2, 21'h15_5555, 16'h9966);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule